// File: doc/BRIEF.md
# Three-Input Chained Integer ALU

This unit evaluates two dependent integer operations in one evaluation. The first operation combines operands A and B. The second operation takes the first operation's result as its left operand and operand C as its right operand. Both results are produced together, so a scheduler can issue a dependent pair as one item. It does not have to wait for the first result to come back through the bypass network.

When both operations are arithmetic, the three operands are compressed by a carry-save stage into a sum vector and a carry vector. One carry-lookahead adder then resolves them, so the dependent result never waits on a full first addition. A second lookahead adder produces the first result in parallel. A logic path (AND, OR, XOR) runs beside each adder, and a multiplexer driven by the opcode selects which path supplies each result. When the first operation is logical and the second is arithmetic, the output of the logic path is routed into the second adder instead of the carry-save vectors.

Inputs are sampled when `in_valid_i` is high. Both results appear together one clock later, with `out_valid_o` asserted.

Top module: `tcalu_top`

## Requirements
- R1: `out_valid_o` is high in exactly the cycle after a cycle in which `in_valid_i` was high, and low otherwise. `res1_o` and `res2_o` are updated on the same edge.
- R2: After reset is released, `out_valid_o` reads 0 until valid input arrives.
- R3: `res1_o` equals `opa_i op1 opb_i`, modulo 2^32. The opcode encoding is 0 = add, 1 = subtract (A minus B), 2 = AND, 3 = OR, 4 = XOR.
- R4: `res2_o` equals `res1 op2 opc_i`, using the same encoding. Subtract computes the first result minus C.
- R5: When both operations are arithmetic, `res2_o` equals A ± B ± C modulo 2^32. Wraparound is exact for all-ones and sign-boundary operands.
- R6: When the first operation is logical and the second is arithmetic, `res2_o` equals the logical result plus or minus C.
- R7: When the first operation is arithmetic and the second is logical, `res2_o` equals the sum or difference combined bitwise with C.
- R8: While `in_valid_i` is low, `res1_o` and `res2_o` keep the values of the last accepted operation.
- R9: Opcode values 5, 6 and 7 behave exactly as add, in either position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| in_valid_i | input | 1 | Operands and opcodes are valid this cycle |
| opa_i | input | 32 | Operand A, left operand of the first operation |
| opb_i | input | 32 | Operand B, right operand of the first operation |
| opc_i | input | 32 | Operand C, right operand of the second operation |
| op1_i | input | 3 | Opcode of the first operation |
| op2_i | input | 3 | Opcode of the second operation |
| out_valid_o | output | 1 | Results valid |
| res1_o | output | 32 | Registered result of the first operation |
| res2_o | output | 32 | Registered result of the dependent second operation |

## Verification
On every cycle, the assertions check the one-cycle valid timing and that results hold between accepted operations. They also check sample opcode pairs covering each path combination: add-add and subtract-subtract through the carry-save stage, AND-AND through the logic paths, add-then-XOR, and XOR-then-add. The full opcode cross product can only be shown by the bench's scenarios. That includes the unused codes acting as add, and exact wraparound with all-ones and sign-boundary operands, which the bench checks against a reference that evaluates the two operations one after the other.

// File: rtl/tcalu_pkg.sv
package tcalu_pkg;
  localparam int OPW = 3;

  typedef enum logic [OPW-1:0] {
    OPC_ADD = 3'd0,
    OPC_SUB = 3'd1,
    OPC_AND = 3'd2,
    OPC_OR  = 3'd3,
    OPC_XOR = 3'd4
  } opc_e;

  function automatic logic is_logic_op(input logic [OPW-1:0] op);
    return (op == OPC_AND) || (op == OPC_OR) || (op == OPC_XOR);
  endfunction

  function automatic logic is_sub_op(input logic [OPW-1:0] op);
    return op == OPC_SUB;
  endfunction
endpackage

// File: rtl/tcalu_rst_sync.sv
module tcalu_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/tcalu_csa.sv
module tcalu_csa #(
  parameter int W = 32
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] z_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);
  logic [W-2:0] maj;

  assign sum_o = x_i ^ y_i ^ z_i;
  assign maj   = (x_i[W-2:0] & y_i[W-2:0]) |
                 (x_i[W-2:0] & z_i[W-2:0]) |
                 (y_i[W-2:0] & z_i[W-2:0]);
  // carry vector shifted up one place; free bit 0 slot takes the injected +1
  assign carry_o = {maj, cin_i};
endmodule

// File: rtl/tcalu_cla.sv
module tcalu_cla #(
  parameter int W   = 32,
  parameter int GRP = 4
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o
);
  localparam int NG = W / GRP;

  logic [NG-1:0] grp_g;
  logic [NG-1:0] grp_p;
  logic [NG-1:0] grp_c;

  // second-level lookahead across groups
  always_comb begin
    grp_c[0] = cin_i;
    for (int k = 1; k < NG; k++) begin
      grp_c[k] = grp_g[k-1] | (grp_p[k-1] & grp_c[k-1]);
    end
  end

  for (genvar k = 0; k < NG; k++) begin : g_grp
    logic [GRP-1:0] g;
    logic [GRP-1:0] p;
    logic [GRP:0]   c;
    logic           gg;

    assign g = x_i[k*GRP +: GRP] & y_i[k*GRP +: GRP];
    assign p = x_i[k*GRP +: GRP] ^ y_i[k*GRP +: GRP];

    always_comb begin
      gg = 1'b0;
      for (int i = 0; i < GRP; i++) gg = g[i] | (p[i] & gg);
    end

    always_comb begin
      c[0] = grp_c[k];
      for (int i = 0; i < GRP; i++) c[i+1] = g[i] | (p[i] & c[i]);
    end

    assign grp_g[k] = gg;
    assign grp_p[k] = &p;
    assign sum_o[k*GRP +: GRP] = p ^ c[GRP-1:0];
  end
endmodule

// File: rtl/tcalu_logic.sv
module tcalu_logic
  import tcalu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]   x_i,
  input  logic [W-1:0]   y_i,
  input  logic [OPW-1:0] op_i,
  output logic [W-1:0]   res_o
);
  always_comb begin
    case (op_i)
      OPC_AND: res_o = x_i & y_i;
      OPC_OR:  res_o = x_i | y_i;
      OPC_XOR: res_o = x_i ^ y_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/tcalu_top.sv
module tcalu_top
  import tcalu_pkg::*;
#(
  parameter int W   = 32,
  parameter int GRP = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           in_valid_i,
  input  logic [W-1:0]   opa_i,
  input  logic [W-1:0]   opb_i,
  input  logic [W-1:0]   opc_i,
  input  logic [OPW-1:0] op1_i,
  input  logic [OPW-1:0] op2_i,
  output logic           out_valid_o,
  output logic [W-1:0]   res1_o,
  output logic [W-1:0]   res2_o
);
  logic         rst_sync_n;
  logic         arith1, arith2, sub1, sub2;
  logic [W-1:0] b_eff, c_eff;
  logic [W-1:0] sum1, lres1, r1;
  logic [W-1:0] csa_s, csa_c;
  logic [W-1:0] add2_x, add2_y, sum2, lres2, r2;
  logic         vld_d, vld_q;
  logic [W-1:0] r1_d, r1_q, r2_d, r2_q;

  tcalu_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  assign arith1 = !is_logic_op(op1_i);
  assign arith2 = !is_logic_op(op2_i);
  assign sub1   = is_sub_op(op1_i);
  assign sub2   = is_sub_op(op2_i);
  assign b_eff  = sub1 ? ~opb_i : opb_i;
  assign c_eff  = sub2 ? ~opc_i : opc_i;

  // first result: own adder beside the first logic path
  tcalu_cla #(.W(W), .GRP(GRP)) u_add1 (
    .x_i(opa_i), .y_i(b_eff), .cin_i(sub1), .sum_o(sum1)
  );
  tcalu_logic #(.W(W)) u_log1 (
    .x_i(opa_i), .y_i(opb_i), .op_i(op1_i), .res_o(lres1)
  );
  assign r1 = arith1 ? sum1 : lres1;

  // collapsed path: A, B', C' compressed; first subtract's +1 rides the carry slot
  tcalu_csa #(.W(W)) u_csa (
    .x_i(opa_i), .y_i(b_eff), .z_i(c_eff), .cin_i(sub1),
    .sum_o(csa_s), .carry_o(csa_c)
  );

  // logical first op: its result is added to C' instead of the CSA vectors
  assign add2_x = arith1 ? csa_s : lres1;
  assign add2_y = arith1 ? csa_c : c_eff;

  tcalu_cla #(.W(W), .GRP(GRP)) u_add2 (
    .x_i(add2_x), .y_i(add2_y), .cin_i(sub2), .sum_o(sum2)
  );
  tcalu_logic #(.W(W)) u_log2 (
    .x_i(r1), .y_i(opc_i), .op_i(op2_i), .res_o(lres2)
  );
  assign r2 = arith2 ? sum2 : lres2;

  // next state, clock enable written out
  always_comb begin
    vld_d = in_valid_i;
    r1_d  = r1_q;
    r2_d  = r2_q;
    if (in_valid_i) begin
      r1_d = r1;
      r2_d = r2;
    end
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
      r1_q  <= '0;
      r2_q  <= '0;
    end else begin
      vld_q <= vld_d;
      r1_q  <= r1_d;
      r2_q  <= r2_d;
    end
  end

  assign out_valid_o = vld_q;
  assign res1_o      = r1_q;
  assign res2_o      = r2_q;
endmodule

// File: rtl/tcalu_chk.sv
module tcalu_chk
  import tcalu_pkg::*;
#(
  parameter int W = 32
) (
  input logic           clk_i,
  input logic           rst_n,
  input logic           in_valid_i,
  input logic [W-1:0]   opa_i,
  input logic [W-1:0]   opb_i,
  input logic [W-1:0]   opc_i,
  input logic [OPW-1:0] op1_i,
  input logic [OPW-1:0] op2_i,
  input logic           out_valid_o,
  input logic [W-1:0]   res1_o,
  input logic [W-1:0]   res2_o
);
  logic [W-1:0] ab_sum, abc_sum, abc_diff, abc_and, absum_xor_c, axb_plus_c;
  logic         is_addadd, is_subsub, is_andand, is_addxor, is_xoradd;

  assign ab_sum      = opa_i + opb_i;
  assign abc_sum     = opa_i + opb_i + opc_i;
  assign abc_diff    = opa_i - opb_i - opc_i;
  assign abc_and     = opa_i & opb_i & opc_i;
  assign absum_xor_c = (opa_i + opb_i) ^ opc_i;
  assign axb_plus_c  = (opa_i ^ opb_i) + opc_i;

  assign is_addadd = in_valid_i && op1_i == OPC_ADD && op2_i == OPC_ADD;
  assign is_subsub = in_valid_i && op1_i == OPC_SUB && op2_i == OPC_SUB;
  assign is_andand = in_valid_i && op1_i == OPC_AND && op2_i == OPC_AND;
  assign is_addxor = in_valid_i && op1_i == OPC_ADD && op2_i == OPC_XOR;
  assign is_xoradd = in_valid_i && op1_i == OPC_XOR && op2_i == OPC_ADD;

  AST_VALID_RISE: assert property (@(posedge clk_i) disable iff (!rst_n)
    in_valid_i |=> out_valid_o);                                      // R1
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    !in_valid_i |=> !out_valid_o);                                    // R1
  AST_HOLD_RESULTS: assert property (@(posedge clk_i) disable iff (!rst_n)
    !in_valid_i |=> ($stable(res1_o) && $stable(res2_o)));            // R8
  AST_FIRST_ADD: assert property (@(posedge clk_i) disable iff (!rst_n)
    is_addadd |=> res1_o == $past(ab_sum));                           // R3
  AST_ADD_ADD: assert property (@(posedge clk_i) disable iff (!rst_n)
    is_addadd |=> res2_o == $past(abc_sum));                          // R5
  AST_SUB_SUB: assert property (@(posedge clk_i) disable iff (!rst_n)
    is_subsub |=> res2_o == $past(abc_diff));                         // R5
  AST_AND_AND: assert property (@(posedge clk_i) disable iff (!rst_n)
    is_andand |=> res2_o == $past(abc_and));                          // R4
  AST_ADD_XOR: assert property (@(posedge clk_i) disable iff (!rst_n)
    is_addxor |=> res2_o == $past(absum_xor_c));                      // R7
  AST_XOR_ADD: assert property (@(posedge clk_i) disable iff (!rst_n)
    is_xoradd |=> res2_o == $past(axb_plus_c));                       // R6
endmodule

bind tcalu_top tcalu_chk #(.W(W)) u_chk (
  .clk_i       (clk_i),
  .rst_n       (rst_sync_n),
  .in_valid_i  (in_valid_i),
  .opa_i       (opa_i),
  .opb_i       (opb_i),
  .opc_i       (opc_i),
  .op1_i       (op1_i),
  .op2_i       (op2_i),
  .out_valid_o (out_valid_o),
  .res1_o      (res1_o),
  .res2_o      (res2_o)
);

// File: tb/tcalu_top_tb.sv
`timescale 1ns/1ps
module tcalu_top_tb;
  typedef struct {
    logic [31:0] r1;
    logic [31:0] r2;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] opa = '0, opb = '0, opc = '0;
  logic [2:0]  op1 = '0, op2 = '0;
  logic        out_valid;
  logic [31:0] res1, res2;

  int   n_tests = 0;
  int   n_fail  = 0;
  exp_t sb_q[$];
  logic vin_q = 1'b0;
  logic mon_en = 1'b0;
  logic have_last = 1'b0;
  logic [31:0] last1 = '0, last2 = '0;

  always #4 clk = ~clk;

  tcalu_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid),
    .opa_i(opa), .opb_i(opb), .opc_i(opc), .op1_i(op1), .op2_i(op2),
    .out_valid_o(out_valid), .res1_o(res1), .res2_o(res2)
  );

  function automatic logic [31:0] ref_op(input logic [31:0] x, input logic [31:0] y,
                                         input logic [2:0] op);
    case (op)
      3'd1:    return x - y;
      3'd2:    return x & y;
      3'd3:    return x | y;
      3'd4:    return x ^ y;
      default: return x + y;
    endcase
  endfunction

  function automatic logic is_log(input logic [2:0] op);
    return op == 3'd2 || op == 3'd3 || op == 3'd4;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                      input logic [2:0] o1, input logic [2:0] o2);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; opa = a; opb = b; opc = c; op1 = o1; op2 = o2;
    e.r1 = ref_op(a, b, o1);
    e.r2 = ref_op(e.r1, c, o2);
    if (o1 > 3'd4 || o2 > 3'd4)           e.tag = "R9";
    else if (!is_log(o1) && !is_log(o2))  e.tag = "R5";
    else if (is_log(o1) && !is_log(o2))   e.tag = "R6";
    else if (!is_log(o1) && is_log(o2))   e.tag = "R7";
    else                                  e.tag = "R4";
    sb_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      opa = $urandom; opb = $urandom; opc = $urandom;
      op1 = 3'($urandom); op2 = 3'($urandom);
    end
  endtask

  always @(posedge clk) vin_q <= in_valid;

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (mon_en) begin
      chk("R1 out_valid timing", {31'b0, out_valid}, {31'b0, vin_q});
      if (out_valid) begin
        if (sb_q.size() == 0) begin
          chk("R1 unexpected result", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk("R3 res1", res1, e.r1);
          chk({e.tag, " res2"}, res2, e.r2);
          last1 = res1; last2 = res2; have_last = 1'b1;
        end
      end else if (have_last) begin
        chk("R8 res1 hold", res1, last1);
        chk("R8 res2 hold", res2, last2);
      end
    end
  end

  initial begin
    fork
      begin
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R2 out_valid after reset", {31'b0, out_valid}, 32'd0);
        mon_en = 1'b1;
        for (int o1 = 0; o1 < 8; o1++) begin
          for (int o2 = 0; o2 < 8; o2++) begin
            for (int k = 0; k < 6; k++) begin
              case (k)
                0: send(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'(o1), 3'(o2));
                1: send(32'h0, 32'h0, 32'h0, 3'(o1), 3'(o2));
                2: send(32'hFFFF_FFFF, 32'h1, 32'hFFFF_FFFF, 3'(o1), 3'(o2));
                3: send(32'h8000_0000, 32'h8000_0000, 32'h7FFF_FFFF, 3'(o1), 3'(o2));
                default: send($urandom, $urandom, $urandom, 3'(o1), 3'(o2));
              endcase
            end
            if (((o1 + o2) % 3) == 0) idle(2);
          end
        end
        idle(3);
        chk("R1 scoreboard drained", sb_q.size(), 32'd0);
      end
      begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule